// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block remaps bus addresses that fall inside a fixed aperture window onto physical memory, one 4 KiB page at a time. The aperture is a contiguous range that starts at a parameter base and spans a parameter number of pages. Each page has one 32-bit table entry. Bit 31 of an entry marks it valid, and bits [30:12] hold the physical page frame. A translated address keeps the low 12 offset bits of the incoming address and takes its upper bits from the frame. The result appears one cycle after the request, together with a fault flag.

Software reaches the table only indirectly, through a three-word register interface. It first writes an aperture address into the entry-select word. A later write to the entry-data word then updates the entry for that page, and a later read of entry-data returns it. A single enable bit in the control word gates all translation. While the block is disabled, every aperture access is reported as a fault. Writing zero to an entry unmaps its page.

Reads of the control word return the live enable state. Software can use such a read as a flush point, because every register write accepted in an earlier cycle has already taken effect when the read data returns.

Top module: `aperture_remap`

## Requirements
- R1: After reset the enable bit is 0, every table entry reads as zero, and every translation faults, even after translation is enabled, until an entry is written.
- R2: Register decode uses reg_addr[3:2] and requires reg_addr[1:0] == 0. The codes are 0 for control (enable in bit 0), 1 for entry-select (all 32 bits read back) and 2 for entry-data. Any other offset reads as zero and ignores writes. reg_rvalid pulses in the cycle after reg_rd, with the data on reg_rdata.
- R3: A write to entry-data updates the entry whose index is (select - APER_BASE) >> 12. Only bits 31 and [30:12] are stored. A read returns the stored bits with [11:0] as zero.
- R4: When the select address lies outside the aperture, a write to entry-data changes no entry, and a read of entry-data returns zero.
- R5: A request with in_valid in cycle n produces out_valid in cycle n+1. When the request does not fault, out_addr = {1'b0, entry[30:12], in_addr[11:0]}.
- R6: While the enable bit is 0, every request faults, and out_addr is zero on every faulting result.
- R7: A request that hits an entry with bit 31 clear faults. Writing zero to an entry unmaps its page.
- R8: A request whose address is below APER_BASE, or at or above APER_BASE + APER_PAGES*4096, faults.
- R9: A control read issued in the cycle after a control write returns the newly written enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| in_valid | input | 1 | Translation request valid |
| in_addr | input | 32 | Incoming bus address |
| out_valid | output | 1 | Translation result valid |
| out_addr | output | 32 | Translated physical address (zero on fault) |
| out_fault | output | 1 | Translation fault flag |

## Verification
The bench builds the block with APER_BASE = 32'h0010_0000 and APER_PAGES = 8. With only eight pages, every entry can be written, read back and translated at several offsets in one pass. The bench also probes both window edges (one byte below the base and the first byte past the end) in the same run. Expected frames and translated addresses come from a simple arithmetic function of the page index. This lets the bench detect a mis-indexed or mis-masked entry at any page.

// File: rtl/aperture_remap_pkg.sv
// Package: shared constants and the stored page-entry type for the
// aperture remapping table. Assumes 32-bit addresses and 4 KiB pages.
package aperture_remap_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int FRAME_W    = ADDR_W - 1 - PAGE_SHIFT;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    typedef enum logic [1:0] {
        RSEL_CTRL = 2'd0,
        RSEL_SEL  = 2'd1,
        RSEL_DATA = 2'd2,
        RSEL_NONE = 2'd3
    } rsel_e;
endpackage

// File: rtl/aperture_window.sv
// Module: aperture_window
// Decides whether an address lies in the aperture and gives its page index.
// Assumes that the aperture does not wrap past the top of the address space.
module aperture_window
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'h4000_0000,
    parameter int          APER_PAGES = 16,
    parameter int          IDX_W      = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(APER_PAGES) << PAGE_SHIFT;

    logic [ADDR_W-1:0] offs;

    // Offset from the base, the range test and the index.
    always_comb begin
        offs = addr - APER_BASE;
        hit  = (addr >= APER_BASE) && ({1'b0, offs} < SPAN);
        idx  = offs[PAGE_SHIFT +: IDX_W];
    end
endmodule

// File: rtl/aperture_table.sv
// Module: aperture_table
// Page-entry storage: one write port and two combinational read ports.
// An index at or above APER_PAGES reads as an invalid entry.
module aperture_table
    import aperture_remap_pkg::*;
#(
    parameter int APER_PAGES = 16,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pte_t             wr_pte,
    input  logic [IDX_W-1:0] rd_idx_a,
    output pte_t             rd_pte_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output pte_t             rd_pte_b
);
    pte_t entries [APER_PAGES];

    for (genvar g = 0; g < APER_PAGES; g++) begin : g_entry
        // Each entry clears on reset and loads when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entries[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                entries[g] <= wr_pte;
        end
    end

    // Guarded reads: an index beyond the table returns an invalid entry.
    always_comb begin
        rd_pte_a = (32'(rd_idx_a) < APER_PAGES) ? entries[rd_idx_a] : '0;
        rd_pte_b = (32'(rd_idx_b) < APER_PAGES) ? entries[rd_idx_b] : '0;
    end
endmodule

// File: rtl/aperture_regs.sv
// Module: aperture_regs
// Three-word register file: enable, entry-select and indirect entry-data.
// Writes take effect at the edge that samples them. Read data is registered,
// so a read always sees every write accepted in earlier cycles.
module aperture_regs
    import aperture_remap_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              ctrl_en,
    output logic [ADDR_W-1:0] sel_addr,
    input  logic              sel_hit,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic              tbl_wr_en,
    output logic [IDX_W-1:0]  tbl_wr_idx,
    output pte_t              tbl_wr_pte,
    input  pte_t              tbl_rd_pte
);
    rsel_e       rsel;
    logic [31:0] rd_mux;

    // Decode the word offset; a misaligned offset selects nothing.
    always_comb begin
        if (reg_addr[1:0] != 2'b00) rsel = RSEL_NONE;
        else                        rsel = rsel_e'(reg_addr[3:2]);
    end

    // Build the table write for an entry-data write inside the aperture.
    always_comb begin
        tbl_wr_en  = reg_wr && (rsel == RSEL_DATA) && sel_hit;
        tbl_wr_idx = sel_idx;
        tbl_wr_pte = pte_t'(reg_wdata[31:PAGE_SHIFT]);
    end

    // Control and select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            sel_addr <= '0;
        end else if (reg_wr) begin
            if (rsel == RSEL_CTRL) ctrl_en  <= reg_wdata[0];
            if (rsel == RSEL_SEL)  sel_addr <= reg_wdata;
        end
    end

    // Read multiplexer over the current register and table state.
    always_comb begin
        unique case (rsel)
            RSEL_CTRL: rd_mux = {31'b0, ctrl_en};
            RSEL_SEL:  rd_mux = sel_addr;
            RSEL_DATA: rd_mux = sel_hit ? {tbl_rd_pte, {PAGE_SHIFT{1'b0}}} : '0;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            reg_rdata  <= reg_rd ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/aperture_xlate.sv
// Module: aperture_xlate
// One-cycle translation stage. It takes the window result and the looked-up
// entry of the request cycle, and registers the address and the fault flag.
module aperture_xlate
    import aperture_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              hit,
    input  pte_t              pte,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_fault
);
    logic bad;

    // A request faults when the block is disabled, misses the window or hits an invalid entry.
    always_comb bad = !en || !hit || !pte.valid;

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            out_fault <= in_valid && bad;
            out_addr  <= (in_valid && !bad) ?
                         {1'b0, pte.frame, in_addr[PAGE_SHIFT-1:0]} : '0;
        end
    end
endmodule

// File: rtl/aperture_remap.sv
// Module: aperture_remap (top)
// Aperture address remapping table with an indirect register interface.
// Assumes one register access per cycle, and that APER_BASE + APER_PAGES*4 KiB
// does not wrap past the top of the address space.
module aperture_remap
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'h4000_0000,
    parameter int          APER_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid,
    input  logic        in_valid,
    input  logic [31:0] in_addr,
    output logic        out_valid,
    output logic [31:0] out_addr,
    output logic        out_fault
);
    localparam int IDX_W = (APER_PAGES > 1) ? $clog2(APER_PAGES) : 1;

    logic              ctrl_en;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_hit, xl_hit;
    logic [IDX_W-1:0]  sel_idx, xl_idx;
    logic              tbl_wr_en;
    logic [IDX_W-1:0]  tbl_wr_idx;
    pte_t              tbl_wr_pte, sel_pte, xl_pte;

    aperture_window #(.APER_BASE(APER_BASE), .APER_PAGES(APER_PAGES), .IDX_W(IDX_W))
        u_sel_win (.addr(sel_addr), .hit(sel_hit), .idx(sel_idx));

    aperture_window #(.APER_BASE(APER_BASE), .APER_PAGES(APER_PAGES), .IDX_W(IDX_W))
        u_xl_win (.addr(in_addr), .hit(xl_hit), .idx(xl_idx));

    aperture_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .ctrl_en(ctrl_en), .sel_addr(sel_addr),
        .sel_hit(sel_hit), .sel_idx(sel_idx), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_idx(tbl_wr_idx), .tbl_wr_pte(tbl_wr_pte), .tbl_rd_pte(sel_pte)
    );

    aperture_table #(.APER_PAGES(APER_PAGES), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx),
        .wr_pte(tbl_wr_pte), .rd_idx_a(sel_idx), .rd_pte_a(sel_pte),
        .rd_idx_b(xl_idx), .rd_pte_b(xl_pte)
    );

    aperture_xlate u_xlate (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .in_valid(in_valid),
        .in_addr(in_addr), .hit(xl_hit), .pte(xl_pte), .out_valid(out_valid),
        .out_addr(out_addr), .out_fault(out_fault)
    );
endmodule

// File: rtl/aperture_remap_checker.sv
// Module: aperture_remap_checker
// Protocol and translation properties, bound into aperture_remap.
module aperture_remap_checker #(
    parameter logic [31:0] APER_BASE  = 32'h4000_0000,
    parameter int          APER_PAGES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_rd,
    input logic        reg_rvalid,
    input logic        in_valid,
    input logic [31:0] in_addr,
    input logic        out_valid,
    input logic [31:0] out_addr,
    input logic        out_fault,
    input logic        ctrl_en
);
    localparam logic [32:0] SPAN = 33'(APER_PAGES) << 12;

    logic        outside;
    logic [31:0] offs;

    // Independent window test on the request address.
    always_comb begin
        offs    = in_addr - APER_BASE;
        outside = (in_addr < APER_BASE) || ({1'b0, offs} >= SPAN);
    end

    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid == $past(reg_rd && rst_n));

    a_r5_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && rst_n));

    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault) |-> (out_addr[11:0] == $past(in_addr[11:0])));

    a_r6_disabled_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctrl_en) |=> out_fault);

    a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_valid && out_addr == 32'h0));

    a_r8_outside_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && outside) |=> out_fault);
endmodule

bind aperture_remap aperture_remap_checker #(
    .APER_BASE(APER_BASE), .APER_PAGES(APER_PAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
    .out_addr(out_addr), .out_fault(out_fault), .ctrl_en(ctrl_en)
);

// File: tb/aperture_remap_bench.sv
// Bench: sweeps every page of an eight-page aperture through register
// programming, read-back and translation, and checks the window edges.
module aperture_remap_bench;
    localparam logic [31:0] BASE  = 32'h0010_0000;
    localparam int          PAGES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, in_valid = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, in_addr = '0;
    logic [31:0] reg_rdata, out_addr;
    logic        reg_rvalid, out_valid, out_fault;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    aperture_remap #(.APER_BASE(BASE), .APER_PAGES(PAGES)) u_aperture_remap (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault)
    );

    function automatic logic [18:0] frame_of(int i);
        return 19'(i * 32'h135 + 32'h7);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] off, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] off, output logic [31:0] d, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = off;
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rvalid === 1'b1, req, {31'b0, reg_rvalid}, 32'h1);
        d = reg_rdata;
    endtask

    task automatic xl(logic [31:0] a, output logic f, output logic [31:0] o);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        f = out_fault;
        o = out_addr;
    endtask

    task automatic expect_fault(logic [31:0] a, string req);
        logic f;
        logic [31:0] o;
        xl(a, f, o);
        check(f === 1'b1 && o === 32'h0, req, {f, o[30:0]}, 32'h8000_0000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d, o;
        logic f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'h0, d, "R1"); check(d === 32'h0, "R1 ctrl", d, 32'h0);
        for (int i = 0; i < PAGES; i++) begin
            wr(4'h4, BASE + 32'(i) * 32'h1000);
            rd(4'h8, d, "R1"); check(d === 32'h0, "R1 entry", d, 32'h0);
        end
        expect_fault(BASE, "R6 disabled");
        wr(4'h0, 32'h1);
        for (int i = 0; i < PAGES; i++) expect_fault(BASE + 32'(i) * 32'h1000 + 32'h10, "R1 invalid");

        // R3: program every page through select/data, then read back
        for (int i = 0; i < PAGES; i++) begin
            wr(4'h4, BASE + 32'(i) * 32'h1000 + 32'(i * 37));
            wr(4'h8, {1'b1, frame_of(i), 12'hABC});
        end
        for (int i = 0; i < PAGES; i++) begin
            wr(4'h4, BASE + 32'(i) * 32'h1000 + 32'hFFF);
            rd(4'h8, d, "R3");
            check(d === {1'b1, frame_of(i), 12'h000}, "R3 readback", d, {1'b1, frame_of(i), 12'h000});
        end

        // R5: translate each page at several offsets
        for (int i = 0; i < PAGES; i++) begin
            for (int k = 0; k < 3; k++) begin
                logic [11:0] off;
                off = (k == 0) ? 12'h000 : (k == 1) ? 12'h5A5 : 12'hFFF;
                xl(BASE + 32'(i) * 32'h1000 + 32'(off), f, o);
                check(f === 1'b0 && o === {1'b0, frame_of(i), off}, "R5 translate", o, {1'b0, frame_of(i), off});
            end
        end

        // R8: window edges
        expect_fault(BASE - 32'h1, "R8 below base");
        expect_fault(BASE + 32'(PAGES) * 32'h1000, "R8 at end");
        expect_fault(32'h0, "R8 zero");
        xl(BASE + 32'(PAGES) * 32'h1000 - 32'h1, f, o);
        check(f === 1'b0, "R8 last byte inside", {31'b0, f}, 32'h0);

        // R4: select outside the aperture
        wr(4'h4, BASE + 32'(PAGES) * 32'h1000);
        wr(4'h8, 32'hFFFF_F000);
        rd(4'h8, d, "R4"); check(d === 32'h0, "R4 outside read", d, 32'h0);
        wr(4'h4, BASE - 32'h1000);
        wr(4'h8, 32'h8000_0000);
        for (int i = 0; i < PAGES; i++) begin
            wr(4'h4, BASE + 32'(i) * 32'h1000);
            rd(4'h8, d, "R4");
            check(d === {1'b1, frame_of(i), 12'h000}, "R4 entry unchanged", d, {1'b1, frame_of(i), 12'h000});
        end

        // R7: unmap page 3 with zero; invalidate page 5 with valid bit clear
        wr(4'h4, BASE + 32'h3000); wr(4'h8, 32'h0);
        rd(4'h8, d, "R7"); check(d === 32'h0, "R7 unmapped read", d, 32'h0);
        expect_fault(BASE + 32'h3123, "R7 unmapped page");
        wr(4'h4, BASE + 32'h5000); wr(4'h8, {1'b0, frame_of(5), 12'h0});
        expect_fault(BASE + 32'h5004, "R7 valid clear");
        xl(BASE + 32'h4004, f, o);
        check(f === 1'b0 && o === {1'b0, frame_of(4), 12'h004}, "R7 neighbour kept", o, {1'b0, frame_of(4), 12'h004});

        // R6 and R9: disable, read back at once, re-enable
        wr(4'h0, 32'h0);
        rd(4'h0, d, "R9"); check(d === 32'h0, "R9 read after disable", d, 32'h0);
        for (int i = 0; i < PAGES; i++) expect_fault(BASE + 32'(i) * 32'h1000, "R6 disabled");
        wr(4'h0, 32'h1);
        rd(4'h0, d, "R9"); check(d === 32'h1, "R9 read after enable", d, 32'h1);

        // R2: select read-back, unused and misaligned offsets
        wr(4'h4, 32'hDEAD_BEEF);
        rd(4'h4, d, "R2"); check(d === 32'hDEAD_BEEF, "R2 select read", d, 32'hDEAD_BEEF);
        rd(4'hC, d, "R2"); check(d === 32'h0, "R2 unused offset", d, 32'h0);
        wr(4'h1, 32'h0);
        rd(4'h0, d, "R2"); check(d === 32'h1, "R2 misaligned write ignored", d, 32'h1);
        rd(4'h2, d, "R2"); check(d === 32'h0, "R2 misaligned read", d, 32'h0);
        @(negedge clk);
        check(reg_rvalid === 1'b0, "R2 rvalid idle", {31'b0, reg_rvalid}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule